// File: doc/BRIEF.md
# Power-On Reset Sequencer

This block generates the synchronous reset for the logic of an FPGA design that has no external reset pin. It watches two asynchronous conditions, a clock-generator lock flag and a supply power-good flag. It releases reset only after both conditions have been seen stable and high, inside the system clock domain, for a programmable number of clock cycles.

The block needs no reset of its own. Every register it holds takes its starting value from the initial value loaded when the device is configured, so the reset output is already asserted when the first clock edge arrives. A lock flag on its own is not trusted to release reset, because a clock generator can report lock wrongly. The power-good flag must also be high. If either flag drops at any time, including a short supply dip after release, reset is forced back on and the whole hold period starts again.

Top module: `por_sequencer`

## Requirements
- R1: `rst_o` is high (asserted) from configuration, before the first clock edge, and the block has no reset input.
- R2: Each flag passes through `SYNC_STAGES` (default 2) clock-domain flip-flops before the block acts on it, so a change on an input is seen internally `SYNC_STAGES` edges later.
- R3: Once both synchronized flags are high, `rst_o` stays high for exactly `HOLD_CYCLES` further edges. With inputs rising between edges, `rst_o` falls at edge number `SYNC_STAGES + HOLD_CYCLES` after the change (edge 18 with the defaults).
- R4: A lock flag alone, or a power-good flag alone, never releases `rst_o`.
- R5: After release, a drop of either flag sets `rst_o` high at edge `SYNC_STAGES + 1` after the drop (the 3rd edge with the defaults) and not earlier.
- R6: Any low cycle of the synchronized qualification restarts the hold count from zero. After a power-good glitch lasting one clock, `rst_o` is high for exactly `HOLD_CYCLES` cycles.
- R7: While both flags stay high after release, `rst_o` stays low indefinitely. The hold count saturates and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| pll_lock_i | input | 1 | Asynchronous clock-generator lock flag, high when locked |
| pwr_good_i | input | 1 | Asynchronous supply power-good flag, high when the supply is valid |
| rst_o | output | 1 | Active-high synchronous reset for downstream logic |

## Verification
In this section, "edge N" counts rising clock edges from the moment an input changes, with inputs changing between edges. With the defaults, a rising qualification takes effect at edge 2 through the synchronizer, and reset release is due at edge 18. A drop is due on `rst_o` at edge 3, and after a one-clock glitch reset is high for exactly 16 cycles.

The bench runs a behavioural model that counts consecutive qualified edges, compares it with `rst_o` at every falling edge, and adds checks at the exact edge counts above. Inputs are driven only on falling edges, so every input change falls between two rising edges.

// File: rtl/por_pkg.sv
package por_pkg;
  // Asynchronous qualification flags, kept together through the synchronizer.
  typedef struct packed {
    logic lock;
    logic pgood;
  } por_flags_t;

  localparam int unsigned POR_FLAG_W = $bits(por_flags_t);
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  // Becomes high after the first edge, so checks skip the configuration state.
  logic armed_q = 1'b0;
  always_ff @(posedge clk_i) armed_q <= 1'b1;

  generate
    if (STAGES <= 1) begin : g_single
      logic [WIDTH-1:0] stage_q = '0;
      always_ff @(posedge clk_i) stage_q <= async_i;
      assign sync_o = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q = '0;
      logic [STAGES-1:0][WIDTH-1:0] stage_d;
      always_comb stage_d = {stage_q[STAGES-2:0], async_i};
      always_ff @(posedge clk_i) stage_q <= stage_d;
      assign sync_o = stage_q[STAGES-1];

      // R2
      sync_shift_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
        stage_q[1] == $past(stage_q[0]));
    end
  endgenerate
endmodule

// File: rtl/por_hold.sv
module por_hold #(
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic qual_i,
  output logic rst_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q = '0;
  logic          rst_q = 1'b1;
  logic [CW-1:0] cnt_d;
  logic          rst_d;
  logic          armed_q = 1'b0;

  always_comb begin
    cnt_d = cnt_q;
    rst_d = 1'b1;
    if (!qual_i) begin
      cnt_d = '0;
    end else if (cnt_q != TERM) begin
      cnt_d = cnt_q + 1'b1;
      rst_d = (cnt_d != TERM);
    end else begin
      rst_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    cnt_q   <= cnt_d;
    rst_q   <= rst_d;
    armed_q <= 1'b1;
  end

  assign rst_o = rst_q;

  // R5
  drop_forces_rst_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    !qual_i |=> rst_q);
  // R6
  drop_clears_cnt_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    !qual_i |=> (cnt_q == '0));
  // R7
  stays_released_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    (qual_i && !rst_q) |=> !rst_q);
  // R3
  release_qualified_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    $fell(rst_q) |-> ($past(qual_i) && $past(cnt_q) == TERM - 1'b1));
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
  parameter int unsigned HOLD_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic pll_lock_i,
  input  logic pwr_good_i,
  output logic rst_o
);
  import por_pkg::*;

  por_flags_t flags_async;
  por_flags_t flags_sync;
  logic       qual;

  always_comb begin
    flags_async.lock  = pll_lock_i;
    flags_async.pgood = pwr_good_i;
  end

  por_sync #(.WIDTH(POR_FLAG_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .async_i(flags_async),
    .sync_o (flags_sync)
  );

  // R4: lock is never trusted without power-good.
  always_comb qual = flags_sync.lock & flags_sync.pgood;

  por_hold #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk_i (clk_i),
    .qual_i(qual),
    .rst_o (rst_o)
  );

  logic armed_q = 1'b0;
  always_ff @(posedge clk_i) armed_q <= 1'b1;

  // R4
  lone_flag_no_release_chk: assert property (@(posedge clk_i) disable iff (!armed_q)
    !(flags_sync.lock && flags_sync.pgood) |=> rst_o);
endmodule

// File: tb/por_sequencer_tb.sv
`timescale 1ns/1ps
module por_sequencer_tb_top;
  localparam int HOLD = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic lock = 1'b0;
  logic pg = 1'b0;
  logic rst;
  int   checks = 0;
  int   errors = 0;
  int   cycles = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  por_sequencer #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .pll_lock_i(lock), .pwr_good_i(pg), .rst_o(rst)
  );

  // Behavioural model: delay lines as queues, run length of qualified edges.
  bit lq[$];
  bit pq[$];
  int run = 0;
  bit exp_rst = 1'b1;
  initial begin
    for (int i = 0; i < SYNC; i++) begin lq.push_back(0); pq.push_back(0); end
  end
  always @(posedge clk) begin
    bit l, p;
    l = lq.pop_front(); p = pq.pop_front();
    lq.push_back(lock); pq.push_back(pg);
    if (l && p) run++; else run = 0;
    exp_rst = !(run >= HOLD);
    cycles++;
  end

  task automatic chk(string req, logic act, logic expv, string what);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, expv);
    end
  endtask

  always @(negedge clk) chk(tag, rst, exp_rst, "model compare");

  task automatic wait_fall(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (rst && n < 200);
  endtask

  initial begin
    int n;
    int hi;
    #0.1;
    chk("R1", rst, 1'b1, "configuration value");

    // R4: lock only, then power-good only
    tag = "R4";
    @(negedge clk); lock = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4", rst, 1'b1, "lock alone");
    lock = 1'b0; pg = 1'b1;
    repeat (40) @(negedge clk);
    chk("R4", rst, 1'b1, "power-good alone");
    pg = 1'b0;
    repeat (5) @(negedge clk);

    // R2 / R3: exact release edge
    tag = "R3";
    lock = 1'b1; pg = 1'b1;
    wait_fall(n);
    checks++;
    if (n != SYNC + HOLD) begin
      errors++;
      $display("FAIL R3 R2 release edge: actual %0d expected %0d", n, SYNC + HOLD);
    end

    // R7: stays released
    tag = "R7";
    repeat (3 * HOLD) @(negedge clk);
    chk("R7", rst, 1'b0, "held release");

    // R5: power-good drop
    tag = "R5";
    pg = 1'b0;
    @(negedge clk); chk("R5", rst, 1'b0, "pg drop edge 1");
    @(negedge clk); chk("R5", rst, 1'b0, "pg drop edge 2");
    @(negedge clk); chk("R5", rst, 1'b1, "pg drop edge 3");
    pg = 1'b1;
    wait_fall(n);
    checks++;
    if (n != SYNC + HOLD) begin
      errors++;
      $display("FAIL R6 restart after pg: actual %0d expected %0d", n, SYNC + HOLD);
    end

    // R5: lock drop
    lock = 1'b0;
    @(negedge clk); @(negedge clk); chk("R5", rst, 1'b0, "lock drop edge 2");
    @(negedge clk); chk("R5", rst, 1'b1, "lock drop edge 3");
    lock = 1'b1;
    wait_fall(n);

    // R6: one-clock power-good glitch
    tag = "R6";
    repeat (5) @(negedge clk);
    pg = 1'b0;
    @(negedge clk); pg = 1'b1;
    @(negedge clk);
    hi = 0;
    for (int k = 0; k < 3 * HOLD; k++) begin
      @(negedge clk);
      if (rst) hi++;
    end
    checks++;
    if (hi != HOLD) begin
      errors++;
      $display("FAIL R6 glitch hold length: actual %0d expected %0d", hi, HOLD);
    end
    chk("R6", rst, 1'b0, "released after glitch");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule